// File: doc/BRIEF.md
# Programmable-Timing Peripheral Bus Cycle Generator

This block turns single-byte host requests, sampled on the host bus clock, into complete read or write cycles on an 8-bit peripheral bus. The peripheral side has an 8-bit address, four active-low device selects, a read strobe, a write strobe, and a data path split into output byte, output enable and input byte. A pad ring combines these into one bidirectional pin set. Two signalling conventions are available. In strobe mode, selects frame the access and separate read and write strobes mark the transfer. In data-strobe mode, the write strobe line carries an active-low read/write level and the selected device line acts as that device's data strobe.

Every phase length is set in whole clocks by a configuration word, and the word is sampled when a request is accepted. A reference point lies two clocks after acceptance (state `REF`). The cycle then moves through the states `SETUP` (address and select setup), `STROBE` (strobe width; zero counts as one), `HOLD` (address and select hold) and `DHOLD` (data hold). A phase of length zero is skipped. The cycle ends in `DONE`, a one-clock state that reports completion, and then returns to `IDLE`. The transitions are: IDLE→REF on an accepted request; REF→SETUP, or REF→STROBE when setup is zero; SETUP→STROBE; STROBE→HOLD, STROBE→DHOLD or STROBE→DONE, skipping zero-length phases; HOLD→DHOLD or HOLD→DONE; DHOLD→DONE; DONE→IDLE.

A window size field zeroes the address bits above the window. Further configuration bits choose whether the data path is driven while idle and whether the clock output runs.

Top module: `lbus_cycle_gen`

## Requirements
- R1: After a request is accepted (`req_valid` high while `busy` is low), all peripheral controls stay inactive for exactly two clocks. The first select or strobe activity appears in the third clock after acceptance, or later by the setup length.
- R2: In strobe mode, the chosen select (`lb_sel_n` bit `req_sel`) is low for `setup` clocks before the strobe begins.
- R3: The strobe is low for `strobe` clocks, and a programmed value of 0 gives exactly 1 clock.
- R4: In strobe mode, the select stays low for `hold` clocks after the strobe ends, so it is low for setup+strobe+hold clocks in total.
- R5: `done` is high for exactly one clock, which comes 2+setup+strobe+hold+dhold clocks after the acceptance edge. For a write, `lb_doe` is high with `lb_dout` equal to the write byte for the setup+strobe+hold+dhold clocks of the active phases.
- R6: `lb_addr` is registered at acceptance and holds until the next acceptance. Bit i of `lb_addr` is zero unless `cfg_win` > i, so `cfg_win` = 0 gives a 1-byte window and 8 or more gives 256 bytes.
- R7: In strobe mode (`cfg_moto` = 0), only select bit `req_sel` is ever low. `lb_rd_n` is the strobe for reads and `lb_wr_n` is the strobe for writes, and the other strobe stays high.
- R8: In data-strobe mode (`cfg_moto` = 1), select bit `req_sel` is low only during the strobe phase. `lb_wr_n` is low from the start of setup to the end of data hold for writes and stays high for reads. `lb_rd_n` stays high.
- R9: No select is low in `DONE` or `IDLE`, so consecutive accesses are separated by idle time. A request presented while `busy` is high is ignored.
- R10: Read data is captured from `lb_din` at the clock edge where the strobe deasserts. It appears on `rdata` together with `done`.
- R11: In `IDLE`, `lb_doe` equals `cfg_idle_drive`. During the setup, strobe and hold phases of a read, `lb_doe` is low.
- R12: `lb_clk` follows `clk` when `cfg_clk_en` is 1 and is held low when it is 0.
- R13: During reset, `busy` and `done` are low, all selects and both strobes are high, and `lb_doe` follows the idle-drive setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address within the window |
| req_wdata | input | 8 | Write byte |
| req_sel | input | 2 | Index of the device select to use |
| cfg_setup | input | 4 | Address/select setup clocks |
| cfg_strobe | input | 4 | Strobe width clocks (0 means 1) |
| cfg_hold | input | 4 | Address/select hold clocks |
| cfg_dhold | input | 4 | Data hold clocks |
| cfg_moto | input | 1 | 1 = read/write line with data strobes |
| cfg_idle_drive | input | 1 | 1 = drive data path while idle |
| cfg_clk_en | input | 1 | Enables the clock output |
| cfg_win | input | 4 | log2 of the address window size |
| busy | output | 1 | High from acceptance to the end of DONE |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured read byte |
| lb_clk | output | 1 | Peripheral clock output |
| lb_addr | output | 8 | Latched peripheral address |
| lb_sel_n | output | 4 | Active-low selects or data strobes |
| lb_rd_n | output | 1 | Active-low read strobe |
| lb_wr_n | output | 1 | Active-low write strobe or read/write line |
| lb_dout | output | 8 | Data to the peripheral |
| lb_doe | output | 1 | Output enable for `lb_dout` |
| lb_din | input | 8 | Data from the peripheral |

## Verification
The bench uses the default parameters: 8-bit address and data, four selects, 4-bit phase fields and a two-clock reference delay. With 4-bit fields, a single run can cover every phase at zero, mid-range and the maximum of 15 clocks. The two-clock reference keeps each cycle's total length short enough that the bench can count strobe start, select width and `done` timing clock by clock. With four selects, every select index can be checked in both signalling modes. With an 8-bit address, window values 0 to 9 can be tested, including the value beyond 8 that must saturate.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    localparam int LB_TW = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DHOLD,
        ST_DONE
    } lbus_state_e;

    typedef struct packed {
        logic [LB_TW-1:0] setup;
        logic [LB_TW-1:0] strobe;
        logic [LB_TW-1:0] hold;
        logic [LB_TW-1:0] dhold;
        logic             moto;
        logic             idle_drive;
    } lbus_timing_t;

endpackage

// File: rtl/lbus_phase_timer.sv
module lbus_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R5: the counter rests at zero and never wraps
    a_r5_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/lbus_addr_window.sv
module lbus_addr_window #(
    parameter int AW = 8,
    parameter int WW = 4
) (
    input  logic [AW-1:0] addr_in,
    input  logic [WW-1:0] win_log2,
    output logic [AW-1:0] addr_out
);
    logic [AW-1:0] keep;

    for (genvar i = 0; i < AW; i++) begin : g_mask
        assign keep[i] = (32'(win_log2) > i);
    end

    assign addr_out = addr_in & keep;

endmodule

// File: rtl/lbus_cycle_gen.sv
module lbus_cycle_gen
    import lbus_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int NSEL     = 4,
    parameter int WW       = 4,
    parameter int REF_CLKS = 2,
    localparam int SELW    = $clog2(NSEL),
    localparam int TW      = LB_TW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [SELW-1:0] req_sel,
    input  logic [TW-1:0]   cfg_setup,
    input  logic [TW-1:0]   cfg_strobe,
    input  logic [TW-1:0]   cfg_hold,
    input  logic [TW-1:0]   cfg_dhold,
    input  logic            cfg_moto,
    input  logic            cfg_idle_drive,
    input  logic            cfg_clk_en,
    input  logic [WW-1:0]   cfg_win,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rdata,
    output logic            lb_clk,
    output logic [AW-1:0]   lb_addr,
    output logic [NSEL-1:0] lb_sel_n,
    output logic            lb_rd_n,
    output logic            lb_wr_n,
    output logic [DW-1:0]   lb_dout,
    output logic            lb_doe,
    input  logic [DW-1:0]   lb_din
);
    localparam logic [TW-1:0] REF_LOAD = TW'(REF_CLKS - 1);

    lbus_state_e  state, state_d;
    lbus_timing_t tcfg;
    logic         wr_q;
    logic [SELW-1:0] sel_q;
    logic [DW-1:0]   wdata_q, rdata_q;
    logic [AW-1:0]   addr_q, addr_masked;
    logic            accept, t_expired, t_load;
    logic [TW-1:0]   t_val, strobe_len;

    assign accept     = (state == ST_IDLE) && req_valid;
    assign strobe_len = (tcfg.strobe == '0) ? TW'(1) : tcfg.strobe;

    lbus_addr_window #(.AW(AW), .WW(WW)) u_window (
        .addr_in  (req_addr),
        .win_log2 (cfg_win),
        .addr_out (addr_masked)
    );

    lbus_phase_timer #(.CW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    // next-state and phase length selection
    always_comb begin
        state_d = state;
        t_val   = '0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_REF;
                    t_val   = REF_LOAD;
                end
            end
            ST_REF: begin
                if (t_expired) begin
                    if (tcfg.setup != '0) begin
                        state_d = ST_SETUP;
                        t_val   = tcfg.setup - 1'b1;
                    end else begin
                        state_d = ST_STROBE;
                        t_val   = strobe_len - 1'b1;
                    end
                end
            end
            ST_SETUP: begin
                if (t_expired) begin
                    state_d = ST_STROBE;
                    t_val   = strobe_len - 1'b1;
                end
            end
            ST_STROBE: begin
                if (t_expired) begin
                    if (tcfg.hold != '0) begin
                        state_d = ST_HOLD;
                        t_val   = tcfg.hold - 1'b1;
                    end else if (tcfg.dhold != '0) begin
                        state_d = ST_DHOLD;
                        t_val   = tcfg.dhold - 1'b1;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_HOLD: begin
                if (t_expired) begin
                    if (tcfg.dhold != '0) begin
                        state_d = ST_DHOLD;
                        t_val   = tcfg.dhold - 1'b1;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DHOLD: begin
                if (t_expired) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign t_load = (state_d != state);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // request capture and read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcfg    <= '0;
            wr_q    <= 1'b0;
            sel_q   <= '0;
            wdata_q <= '0;
            addr_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                tcfg    <= '{setup: cfg_setup, strobe: cfg_strobe, hold: cfg_hold,
                             dhold: cfg_dhold, moto: cfg_moto, idle_drive: cfg_idle_drive};
                wr_q    <= req_write;
                sel_q   <= req_sel;
                wdata_q <= req_wdata;
                addr_q  <= addr_masked;
            end
            if (state == ST_STROBE && state_d != ST_STROBE && !wr_q)
                rdata_q <= lb_din;
        end
    end

    // outputs decoded from the state
    logic [NSEL-1:0] dev_hot;
    logic            sel_phase, stb_phase, drv_phase, idle_phase, idle_drv;

    always_comb begin
        dev_hot    = NSEL'(1) << sel_q;
        sel_phase  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        stb_phase  = (state == ST_STROBE);
        drv_phase  = wr_q && (sel_phase || state == ST_DHOLD);
        idle_phase = (state == ST_IDLE) || (state == ST_REF) || (state == ST_DONE);
        idle_drv   = (state == ST_IDLE) ? cfg_idle_drive : tcfg.idle_drive;

        if (tcfg.moto) begin
            lb_sel_n = stb_phase ? ~dev_hot : '1;
            lb_rd_n  = 1'b1;
            lb_wr_n  = !drv_phase;
        end else begin
            lb_sel_n = sel_phase ? ~dev_hot : '1;
            lb_rd_n  = !(stb_phase && !wr_q);
            lb_wr_n  = !(stb_phase && wr_q);
        end

        lb_doe  = drv_phase || (idle_phase && idle_drv);
        lb_dout = wdata_q;
        lb_addr = addr_q;
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        rdata   = rdata_q;
    end

    assign lb_clk = clk & cfg_clk_en;

    // R7: never more than one select low
    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~lb_sel_n));

    // R7: read and write strobes never low together
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lb_rd_n && !lb_wr_n));

    // R1: controls stay inactive through the reference delay
    a_r1_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (busy && lb_sel_n == '1 && lb_rd_n && lb_wr_n));

    // R6: address holds for the whole cycle
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lb_addr));

    // R5: done is a single clock
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an idle clock always follows completion
    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && lb_sel_n == '1));

    // R8: read strobe unused in data-strobe mode
    a_r8_no_rd_in_moto: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tcfg.moto) |-> lb_rd_n);

endmodule

// File: tb/lbus_cycle_gen_test.sv
module lbus_cycle_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic [1:0] req_sel = '0;
    logic [3:0] cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0, cfg_dhold = '0, cfg_win = 4'd8;
    logic       cfg_moto = 1'b0, cfg_idle_drive = 1'b0, cfg_clk_en = 1'b0;
    logic       busy, done, lb_clk, lb_rd_n, lb_wr_n, lb_doe;
    logic [7:0] rdata, lb_addr, lb_dout;
    logic [7:0] lb_din = 8'hEE;
    logic [3:0] lb_sel_n;

    always #2.5 clk = ~clk;

    lbus_cycle_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_sel(req_sel),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .cfg_dhold(cfg_dhold), .cfg_moto(cfg_moto), .cfg_idle_drive(cfg_idle_drive),
        .cfg_clk_en(cfg_clk_en), .cfg_win(cfg_win), .busy(busy), .done(done),
        .rdata(rdata), .lb_clk(lb_clk), .lb_addr(lb_addr), .lb_sel_n(lb_sel_n),
        .lb_rd_n(lb_rd_n), .lb_wr_n(lb_wr_n), .lb_dout(lb_dout), .lb_doe(lb_doe),
        .lb_din(lb_din)
    );

    int checks = 0, fails = 0, ndone = 0;
    logic [7:0] periph_byte = 8'h00;

    typedef struct {
        bit wr; logic [7:0] addr; logic [7:0] data; int dev;
        int s; int w; int h; int d; bit moto;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // peripheral model: valid read byte only while its read strobe is low
    always @(negedge clk) begin
        if (cfg_moto) lb_din <= (lb_sel_n != 4'hF && lb_wr_n) ? periph_byte : 8'hEE;
        else          lb_din <= (!lb_rd_n) ? periph_byte : 8'hEE;
    end

    // monitor
    bit in_txn = 0;
    int k, stb_first, stb_len, sel_len, doe_len, rw_len, wrong, dout_bad;
    logic [7:0] addr_seen;
    logic [3:0] sel_seen;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && busy && sb.size() > 0) begin
                exp_t e;
                bit stb;
                e = sb[0];
                if (!in_txn) begin
                    in_txn = 1; k = 0; stb_first = -1; stb_len = 0; sel_len = 0;
                    doe_len = 0; rw_len = 0; wrong = 0; dout_bad = 0;
                    addr_seen = '0; sel_seen = 4'hF;
                end else k++;
                stb = e.moto ? (lb_sel_n != 4'hF) : (!lb_rd_n || !lb_wr_n);
                if (stb) begin
                    if (stb_first < 0) stb_first = k;
                    stb_len++;
                    addr_seen = lb_addr;
                    sel_seen  = lb_sel_n;
                    if (e.wr && !(lb_doe && lb_dout == e.data)) dout_bad++;
                    if (!e.wr && lb_doe) dout_bad++;
                end
                if (lb_sel_n != 4'hF) sel_len++;
                if (e.wr && lb_doe) doe_len++;
                if (e.moto && !lb_wr_n) rw_len++;
                if (e.moto ? !lb_rd_n : (e.wr ? !lb_rd_n : !lb_wr_n)) wrong++;
                if (done) begin
                    int wq, tot;
                    wq  = (e.w == 0) ? 1 : e.w;
                    tot = e.s + wq + e.h + e.d;
                    void'(sb.pop_front());
                    chk(k == 2 + tot, "R5", "done cycle", k, 2 + tot);
                    chk(stb_first == 2 + e.s, "R1", "strobe start", stb_first, 2 + e.s);
                    chk(stb_len == wq, "R3", "strobe width", stb_len, wq);
                    chk(addr_seen == e.addr, "R6", "masked address", addr_seen, e.addr);
                    chk(sel_seen == ~(4'b1 << e.dev), "R7", "select line", sel_seen, ~(4'b1 << e.dev));
                    chk(lb_sel_n == 4'hF, "R9", "select idle in done", lb_sel_n, 4'hF);
                    chk(wrong == 0, "R7 R8", "wrong strobe cycles", wrong, 0);
                    chk(dout_bad == 0, "R5 R11", "data drive in strobe", dout_bad, 0);
                    if (e.moto) begin
                        chk(sel_len == wq, "R8", "data strobe width", sel_len, wq);
                        chk(rw_len == (e.wr ? tot : 0), "R8", "rw line low", rw_len, e.wr ? tot : 0);
                    end else begin
                        chk(sel_len == e.s + wq + e.h, "R2 R4", "select width", sel_len, e.s + wq + e.h);
                    end
                    if (e.wr) chk(doe_len == tot, "R5", "write drive cycles", doe_len, tot);
                    else      chk(rdata == e.data, "R10", "read byte", rdata, e.data);
                    ndone++;
                end
            end else if (rst_n && done && sb.size() == 0) begin
                chk(0, "R9", "unexpected done", 1, 0);
            end else if (!busy) begin
                in_txn = 0;
            end
        end
    end

    task automatic run(input bit wr, input logic [7:0] addr, input int win,
                       input logic [7:0] data, input int dev, input int s, input int w,
                       input int h, input int d, input bit moto, input bit idle, input bit poke);
        exp_t e;
        int n0;
        logic [7:0] keep;
        keep = '0;
        for (int i = 0; i < 8; i++) if (win > i) keep[i] = 1'b1;
        e = '{wr, addr & keep, data, dev, s, w, h, d, moto};
        @(negedge clk);
        cfg_setup = 4'(s); cfg_strobe = 4'(w); cfg_hold = 4'(h); cfg_dhold = 4'(d);
        cfg_moto = moto; cfg_idle_drive = idle; cfg_win = 4'(win);
        req_write = wr; req_addr = addr; req_wdata = data; req_sel = 2'(dev);
        periph_byte = data;
        sb.push_back(e);
        n0 = ndone;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b1; req_addr = 8'h5A; req_write = ~wr;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait (ndone == n0 + 1);
        if (poke) begin
            repeat (8) @(negedge clk);
            chk(!busy && ndone == n0 + 1, "R9", "request during busy ignored", ndone - n0, 1);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!busy && !done, "R13", "busy/done in reset", {busy, done}, 0);
        chk(lb_sel_n == 4'hF && lb_rd_n && lb_wr_n, "R13", "controls in reset",
            {lb_sel_n, lb_rd_n, lb_wr_n}, 6'h3F);
        chk(!lb_doe, "R13", "doe in reset", lb_doe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: idle drive follows the configuration
        cfg_idle_drive = 1'b1; #1;
        chk(lb_doe, "R11", "idle drive on", lb_doe, 1);
        cfg_idle_drive = 1'b0; #1;
        chk(!lb_doe, "R11", "idle drive off", lb_doe, 0);

        // R12: clock output enable
        cfg_clk_en = 1'b1;
        @(posedge clk); #1;
        chk(lb_clk, "R12", "clock high phase", lb_clk, 1);
        @(negedge clk); #1;
        chk(!lb_clk, "R12", "clock low phase", lb_clk, 0);
        cfg_clk_en = 1'b0;
        @(posedge clk); #1;
        chk(!lb_clk, "R12", "clock gated", lb_clk, 0);

        // strobe mode write, mid settings (R2 R3 R4 R5 R7)
        run(1, 8'hA7, 8, 8'h3C, 1, 1, 2, 1, 1, 0, 0, 0);
        // strobe mode read, all phases minimum, 16-byte window (R3 zero width, R6)
        run(0, 8'hF6, 4, 8'h96, 2, 0, 0, 0, 0, 0, 0, 0);
        // longer read, window saturates above 8 (R6 R10)
        run(0, 8'hC3, 9, 8'h5A, 3, 3, 3, 2, 2, 0, 0, 0);
        // 1-byte window (R6)
        run(1, 8'hFF, 0, 8'h81, 0, 0, 1, 0, 2, 0, 0, 0);
        // data-strobe write (R8)
        run(1, 8'h12, 8, 8'hE1, 2, 2, 1, 1, 2, 1, 0, 0);
        // data-strobe read with idle drive on: no drive during strobe (R8 R10 R11)
        run(0, 8'h34, 8, 8'h7E, 1, 1, 2, 0, 1, 1, 1, 0);
        // maxima with a poke during busy (R5 R9)
        run(1, 8'h6B, 8, 8'h0F, 3, 15, 15, 15, 15, 0, 0, 1);
        // read poked during busy (R9)
        run(0, 8'h21, 8, 8'hD4, 0, 4, 2, 3, 0, 0, 0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule